// File: doc/BRIEF.md
# Serial-Load Display Driver Register

This block holds display data for a row of display segments or grids. Bits arrive one at a time on a serial input and are clocked into a chain of `NUM_OUT` stages by a shift clock. The last stage is brought out on a serial output, so several drivers can be chained into one long string. A strobe copies the whole chain into an output latch at once. This means new data can be shifted in while the old picture stays on the outputs.

Two level controls sit between the latch and the outputs. An enable input blanks every output when it is low, and this blanking has the highest priority. A lamp-test input lights every output when the enable is high. The chain and the latch can be cleared without the reset: raise the strobe, then give one shift-clock edge. This is useful at power-up.

The shift clock and the strobe are plain input levels, not clocks. They are sampled in the single system clock domain, and their rising edges are found by comparing each sample with the one taken a cycle earlier. The enable and lamp-test inputs are also sampled before they reach the output stage.

Top module: `vfd_shift_driver`

## Requirements
- R1: The first system clock edge that samples the shift clock high after a low sample is a shift edge. On that edge, provided the strobe is low, the serial input enters stage 1 (output bit 0). Each stage k moves into stage k+1.
- R2: Data is positive logic. In normal display mode, a 1 in latch bit k drives output bit k high, and a 0 drives it low.
- R3: The serial output always equals the last stage (stage `NUM_OUT`). It therefore changes only on shift edges and clears.
- R4: On the first system clock edge that samples the strobe high after a low sample, the latch takes a copy of every stage. At all other times the latch holds its value, including while data is being shifted.
- R5: A shift edge that occurs while the strobe is sampled high clears every stage and every latch bit to 0. The clear wins over both the shift and the load.
- R6: When the enable and lamp-test inputs were both high at the previous system clock edge, all outputs are 1 whatever the latch holds.
- R7: When the enable input was low at the previous system clock edge, all outputs are 0 whatever the lamp-test input and the latch hold.
- R8: When the enable input was high and the lamp-test input was low at the previous system clock edge, each output equals its latch bit.
- R9: The asynchronous active-low reset clears the chain, the latch and the sampled controls. After reset the outputs are blanked and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_clk | input | 1 | Shift clock level, sampled; a rising edge shifts in one bit |
| ser_in | input | 1 | Serial display data, positive logic |
| load_stb | input | 1 | Latch strobe level; a rising edge loads the latch, and a high level turns a shift edge into a clear |
| out_en | input | 1 | Output enable; low blanks every output |
| lamp_test | input | 1 | Lights every output while the enable is high |
| ser_out | output | 1 | Last stage of the chain, for cascading |
| drv | output | NUM_OUT | Driver outputs; bit 0 is stage 1 |

## Verification
The bench builds the block with `NUM_OUT` = 8. At that size it can shift, latch and check every one of the 256 possible patterns, so each bit position is seen at both levels against all of its neighbours. Each pattern is shifted in over the previous one. This lets the serial output be checked bit by bit against the pattern before it. It also shows the latch holding the old pattern until the strobe arrives. At regular points in the sweep, the bench steps through all four combinations of enable and lamp test. It also tests the clear path from both a full chain and a full latch.

// File: rtl/vfd_shift_driver.sv
module vfd_shift_driver #(
  parameter int NUM_OUT = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_clk,
  input  logic               ser_in,
  input  logic               load_stb,
  input  logic               out_en,
  input  logic               lamp_test,
  output logic               ser_out,
  output logic [NUM_OUT-1:0] drv
);

  logic [NUM_OUT-1:0] stage_q;
  logic [NUM_OUT-1:0] hold_q;
  logic               shift_clk_q;
  logic               load_stb_q;
  logic               out_en_q;
  logic               lamp_test_q;

  logic shift_edge;
  logic load_edge;
  logic wipe;

  assign shift_edge = shift_clk & ~shift_clk_q;
  assign load_edge  = load_stb & ~load_stb_q;
  assign wipe       = shift_edge & load_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_clk_q <= 1'b0;
      load_stb_q  <= 1'b0;
      out_en_q    <= 1'b0;
      lamp_test_q <= 1'b0;
      stage_q     <= '0;
      hold_q      <= '0;
    end else begin
      shift_clk_q <= shift_clk;
      load_stb_q  <= load_stb;
      out_en_q    <= out_en;
      lamp_test_q <= lamp_test;
      if (wipe) begin
        stage_q <= '0;
        hold_q  <= '0;
      end else begin
        if (shift_edge) stage_q <= {stage_q[NUM_OUT-2:0], ser_in};
        if (load_edge)  hold_q  <= stage_q;
      end
    end
  end

  assign ser_out = stage_q[NUM_OUT-1];
  assign drv     = !out_en_q ? '0 : (lamp_test_q ? '1 : hold_q);

endmodule

// File: rtl/vfd_shift_driver_chk.sv
module vfd_shift_driver_chk #(
  parameter int NUM_OUT = 60
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift_clk,
  input logic               shift_clk_q,
  input logic               ser_in,
  input logic               load_stb,
  input logic               load_stb_q,
  input logic               out_en,
  input logic               lamp_test,
  input logic               ser_out,
  input logic [NUM_OUT-1:0] stage_q,
  input logic [NUM_OUT-1:0] hold_q,
  input logic [NUM_OUT-1:0] drv
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_clk && !shift_clk_q && !load_stb) |=> (stage_q[0] == $past(ser_in))); // R1

  AST_SER_OUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_clk && !shift_clk_q && !load_stb) |=> (ser_out == $past(stage_q[NUM_OUT-2]))); // R3

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !load_stb_q && !(shift_clk && !shift_clk_q)) |=> (hold_q == $past(stage_q))); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stb && !load_stb_q) && !(shift_clk && !shift_clk_q && load_stb) |=> $stable(hold_q)); // R4

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_clk && !shift_clk_q && load_stb) |=> (stage_q == '0 && hold_q == '0 && !ser_out)); // R5

  AST_LAMP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(out_en) && $past(lamp_test)) |-> (&drv)); // R6

  AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(out_en)) |-> (drv == '0)); // R7

endmodule

bind vfd_shift_driver vfd_shift_driver_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .shift_clk_q(shift_clk_q),
  .ser_in(ser_in), .load_stb(load_stb), .load_stb_q(load_stb_q),
  .out_en(out_en), .lamp_test(lamp_test), .ser_out(ser_out),
  .stage_q(stage_q), .hold_q(hold_q), .drv(drv)
);

// File: tb/tb_vfd_shift_driver.sv
`timescale 1ns/1ps
module tb_vfd_shift_driver;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b0, ser_in = 1'b0, load_stb = 1'b0;
  logic out_en = 1'b0, lamp_test = 1'b0;
  logic ser_out;
  logic [N-1:0] drv;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vfd_shift_driver #(.NUM_OUT(N)) dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
    .load_stb(load_stb), .out_en(out_en), .lamp_test(lamp_test),
    .ser_out(ser_out), .drv(drv)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b; shift_clk = 1'b1;
    tick();
    @(negedge clk); shift_clk = 1'b0;
    tick();
  endtask

  task automatic strobe();
    @(negedge clk); load_stb = 1'b1;
    tick();
    @(negedge clk); load_stb = 1'b0;
    tick();
  endtask

  task automatic set_ctl(input logic en, input logic lt);
    @(negedge clk); out_en = en; lamp_test = lt;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset drv", drv, '0);
    chk("R9 reset ser_out", {{(N-1){1'b0}}, ser_out}, '0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R7 blank after reset", drv, '0);
    set_ctl(1'b1, 1'b0);
    chk("R9 latch empty after reset", drv, '0);

    prev = '0;
    for (int p = 0; p < (1 << N); p++) begin
      logic [N-1:0] pat;
      pat = p[N-1:0];
      for (int j = 1; j <= N; j++) begin
        shift_bit(pat[N-j]);
        if (j < N) chk("R1 R3 ser_out cascade", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, prev[N-1-j]});
        else       chk("R1 R3 ser_out new top", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, pat[N-1]});
      end
      chk("R4 latch holds while shifting", drv, prev);
      strobe();
      chk("R2 R8 latched pattern", drv, pat);
      if (p % 17 == 5) begin
        set_ctl(1'b1, 1'b1);
        chk("R6 lamp test all on", drv, '1);
        set_ctl(1'b0, 1'b1);
        chk("R7 blank beats lamp test", drv, '0);
        set_ctl(1'b0, 1'b0);
        chk("R7 blank", drv, '0);
        set_ctl(1'b1, 1'b0);
        chk("R8 back to latch", drv, pat);
      end
      prev = pat;
    end

    // clear path: chain and latch both full
    for (int j = 0; j < N; j++) shift_bit(1'b1);
    strobe();
    chk("R4 ones latched", drv, '1);
    @(negedge clk); load_stb = 1'b1;
    tick();
    chk("R4 strobe reloads ones", drv, '1);
    @(negedge clk); shift_clk = 1'b1; ser_in = 1'b1;
    tick();
    chk("R5 clear latch", drv, '0);
    chk("R5 clear chain top", {{(N-1){1'b0}}, ser_out}, '0);
    @(negedge clk); shift_clk = 1'b0; load_stb = 1'b0;
    tick();
    strobe();
    chk("R5 chain empty after clear", drv, '0);

    // clear from mixed chain with stale latch
    for (int j = 0; j < N; j++) shift_bit(j[0]);
    strobe();
    chk("R1 alternating pattern", drv, {(N/2){2'b01}});
    @(negedge clk); load_stb = 1'b1; shift_clk = 1'b1;
    tick();
    chk("R5 clear wins over load", drv, '0);
    @(negedge clk); load_stb = 1'b0; shift_clk = 1'b0;
    tick();
    set_ctl(1'b1, 1'b1);
    chk("R6 lamp test after clear", drv, '1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule